// File: doc/BRIEF.md
# L2 Forwarding Table Search Unit

This block carries out the read-side lookups on a 2048-entry L2 forwarding table organised as a hash table. A command engine gives it a method code, a start index, a 4-bit port filter and a key (MAC address and FID). The block then does one of three things:

- It reads a single slot, either directly by index or at the slot derived from the key.
- It compares the key with the entry stored in that one derived slot.
- It walks forward from the start index, one entry per clock, until it finds the first valid entry that passes a unicast, multicast or source-port filter.

When the search ends, the block pulses done and reports a hit flag, the matched index and the full stored entry. These results stay stable until the next completed search.

The table storage sits outside the block, behind a synchronous read port with one cycle of latency. The block drives `rd_en_o` and `rd_addr_o`, and the stored entry comes back on `rd_data_i` in the next cycle. Reads are issued back to back, so the walk needs no stall cycles. A miss over the whole remaining range takes at most 2049 cycles.

Top module: `l2s_search_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `hit_o` and `rd_en_o` are all 0.
- R2: An entry on `rd_data_i` is packed as valid [65], MAC [64:17], FID [16:5], source port [4:1], static [0]. Method 1 reads only slot `start_addr_i`. It hits exactly when that entry is valid, issues exactly one table read, and asserts `done_o` 2 cycles after the start edge.
- R3: Method 0 examines only the slot given by the low 11 bits of (MAC XOR zero-extended FID). It hits when that entry is valid and its MAC and FID both equal the key; port and static bits are not compared. On a hit, `index_o` is that slot and `entry_o` is the full stored entry. It issues one read and finishes 2 cycles after start.
- R4: Method 2 examines indices in ascending order from `start_addr_i`, one per cycle, and returns the first valid entry. A hit at offset k from the start finishes k+2 cycles after the start edge.
- R5: Method 3 accepts only valid unicast entries and method 4 only valid multicast entries. An entry is multicast when MAC bit 40 (bit 0 of the first octet) is 1.
- R6: Method 7 accepts only valid unicast entries whose source port equals `port_i`.
- R7: A scan stops after index 2047 and does not wrap. When nothing qualifies, `hit_o` is 0 and done comes 1 + (2048 − start) cycles after the start edge.
- R8: Method codes 5 and 6 are reserved. They finish with `hit_o` = 0 one cycle after start, and issue no table read.
- R9: `done_o` is a single-cycle pulse. `hit_o`, `index_o` and `entry_o` hold their values until the next `done_o`.
- R10: `start_i` is ignored while `busy_o` is 1.
- R11: Within one search, consecutive table reads use consecutive ascending addresses. After a read of index 2047, no further read follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a search (sampled while idle) |
| method_i | input | 3 | Search method code |
| start_addr_i | input | 11 | Start index / direct index |
| port_i | input | 4 | Source-port filter for method 7 |
| key_mac_i | input | 48 | Key MAC address for method 0 |
| key_fid_i | input | 12 | Key FID for method 0 |
| busy_o | output | 1 | Search in progress |
| rd_en_o | output | 1 | Table read request |
| rd_addr_o | output | 11 | Table read index |
| rd_data_i | input | 66 | Table entry, one cycle after request |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | A qualifying entry was found |
| index_o | output | 11 | Index of the matched entry |
| entry_o | output | 66 | Contents of the matched entry |

## Verification
The table is seeded with a sparse mix of valid unicast, valid multicast and invalid entries, with ports chosen so that each filter must skip an entry the plain next-valid walk would take. The key method is driven with an exact match, with a key that hashes to an empty slot, and with a different key that collides on an occupied slot; together these separate a correct slot compare from a slot-only hit. The walks are started at the table end, just past the only multicast entry and ahead of an invalid entry with a matching port. These starting points tell a correct stop at the end apart from wrap-around, and a correct validity test apart from a filter that ignores the valid bit. Reserved codes and a start pulse raised in the middle of a long walk confirm that done arrives in the exact cycle predicted by the behavioural model.

// File: rtl/l2s_pkg.sv
package l2s_pkg;
  parameter int IDX_W  = 11;
  parameter int MAC_W  = 48;
  parameter int FID_W  = 12;
  parameter int PORT_W = 4;
  parameter int MTH_W  = 3;
  localparam int ENT_W = 1 + MAC_W + FID_W + PORT_W + 1;
  localparam int MC_BIT = MAC_W - 8;

  localparam logic [MTH_W-1:0] M_KEY       = 3'd0;
  localparam logic [MTH_W-1:0] M_ADDR      = 3'd1;
  localparam logic [MTH_W-1:0] M_NEXT      = 3'd2;
  localparam logic [MTH_W-1:0] M_NEXT_UC   = 3'd3;
  localparam logic [MTH_W-1:0] M_NEXT_MC   = 3'd4;
  localparam logic [MTH_W-1:0] M_NEXT_PORT = 3'd7;

  typedef struct packed {
    logic              valid;
    logic [MAC_W-1:0]  mac;
    logic [FID_W-1:0]  fid;
    logic [PORT_W-1:0] port;
    logic              stat;
  } l2_entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_RSV} ctl_state_e;

  function automatic logic [IDX_W-1:0] key_slot(input logic [MAC_W-1:0] mac,
                                                 input logic [FID_W-1:0] fid);
    logic [MAC_W-1:0] x;
    x = mac ^ MAC_W'(fid);
    return x[IDX_W-1:0];
  endfunction

  function automatic logic is_reserved(input logic [MTH_W-1:0] m);
    return !(m == M_KEY || m == M_ADDR || m == M_NEXT || m == M_NEXT_UC ||
             m == M_NEXT_MC || m == M_NEXT_PORT);
  endfunction

  function automatic logic is_single(input logic [MTH_W-1:0] m);
    return (m == M_KEY) || (m == M_ADDR);
  endfunction
endpackage

// File: rtl/l2s_match.sv
module l2s_match
  import l2s_pkg::*;
(
  input  logic [MTH_W-1:0]  method_i,
  input  l2_entry_t         ent_i,
  input  logic [MAC_W-1:0]  key_mac_i,
  input  logic [FID_W-1:0]  key_fid_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              qual_o
);
  logic mc;
  logic unused_stat;

  assign mc          = ent_i.mac[MC_BIT];
  assign unused_stat = ent_i.stat;

  always_comb begin
    qual_o = 1'b0;
    case (method_i)
      M_KEY:       qual_o = ent_i.valid && (ent_i.mac == key_mac_i) && (ent_i.fid == key_fid_i);
      M_ADDR,
      M_NEXT:      qual_o = ent_i.valid;
      M_NEXT_UC:   qual_o = ent_i.valid && !mc;
      M_NEXT_MC:   qual_o = ent_i.valid && mc;
      M_NEXT_PORT: qual_o = ent_i.valid && !mc && (ent_i.port == port_i);
      default:     qual_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/l2s_walker.sv
module l2s_walker #(
  parameter int IDX_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [IDX_W-1:0] first_addr_i,
  input  logic             single_i,
  input  logic             halt_i,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_addr_o,
  output logic             chk_vld_o,
  output logic [IDX_W-1:0] chk_addr_o,
  output logic             chk_last_o
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  logic             iss_act;
  logic [IDX_W-1:0] iss_addr;
  logic             iss_single;
  logic             iss_last;

  assign iss_last  = iss_single || (iss_addr == LAST);
  assign rd_en_o   = iss_act;
  assign rd_addr_o = iss_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_act    <= 1'b0;
      iss_addr   <= '0;
      iss_single <= 1'b0;
    end else if (launch_i) begin
      iss_act    <= 1'b1;
      iss_addr   <= first_addr_i;
      iss_single <= single_i;
    end else if (halt_i) begin
      iss_act <= 1'b0;
    end else if (iss_act) begin
      if (iss_last) iss_act  <= 1'b0;
      else          iss_addr <= iss_addr + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_vld_o  <= 1'b0;
      chk_addr_o <= '0;
      chk_last_o <= 1'b0;
    end else begin
      chk_vld_o  <= iss_act && !halt_i;
      chk_addr_o <= iss_addr;
      chk_last_o <= iss_last;
    end
  end

  p_read_order_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + 1'b1));

  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && rd_addr_o == LAST) |=> !rd_en_o);
endmodule

// File: rtl/l2s_result.sv
module l2s_result
  import l2s_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fin_i,
  input  logic             fin_hit_i,
  input  logic [IDX_W-1:0] fin_idx_i,
  input  l2_entry_t        fin_ent_i,
  output logic             done_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] index_o,
  output l2_entry_t        entry_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      hit_o   <= 1'b0;
      index_o <= '0;
      entry_o <= '0;
    end else begin
      done_o <= fin_i;
      if (fin_i) begin
        hit_o <= fin_hit_i;
        if (fin_hit_i) begin
          index_o <= fin_idx_i;
          entry_o <= fin_ent_i;
        end
      end
    end
  end
endmodule

// File: rtl/l2s_search_unit.sv
module l2s_search_unit
  import l2s_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [MTH_W-1:0]     method_i,
  input  logic [IDX_W-1:0]     start_addr_i,
  input  logic [PORT_W-1:0]    port_i,
  input  logic [MAC_W-1:0]     key_mac_i,
  input  logic [FID_W-1:0]     key_fid_i,
  output logic                 busy_o,
  output logic                 rd_en_o,
  output logic [IDX_W-1:0]     rd_addr_o,
  input  logic [ENT_W-1:0]     rd_data_i,
  output logic                 done_o,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     index_o,
  output logic [ENT_W-1:0]     entry_o
);
  ctl_state_e        state;
  logic [MTH_W-1:0]  method_q;
  logic [PORT_W-1:0] port_q;
  logic [MAC_W-1:0]  key_mac_q;
  logic [FID_W-1:0]  key_fid_q;

  logic             accept, launch, fin, fin_hit, qual;
  logic [IDX_W-1:0] first_addr;
  logic             chk_vld, chk_last;
  logic [IDX_W-1:0] chk_addr;
  l2_entry_t        rd_ent, res_ent;

  assign rd_ent     = l2_entry_t'(rd_data_i);
  assign accept     = (state == ST_IDLE) && start_i;
  assign launch     = accept && !is_reserved(method_i);
  assign first_addr = (method_i == M_KEY) ? key_slot(key_mac_i, key_fid_i) : start_addr_i;
  assign busy_o     = (state != ST_IDLE);

  always_comb begin
    fin     = 1'b0;
    fin_hit = 1'b0;
    if (state == ST_RSV) begin
      fin = 1'b1;
    end else if (state == ST_SCAN && chk_vld) begin
      fin     = qual || chk_last;
      fin_hit = qual;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      method_q  <= '0;
      port_q    <= '0;
      key_mac_q <= '0;
      key_fid_q <= '0;
    end else begin
      if (accept) begin
        method_q  <= method_i;
        port_q    <= port_i;
        key_mac_q <= key_mac_i;
        key_fid_q <= key_fid_i;
        state     <= is_reserved(method_i) ? ST_RSV : ST_SCAN;
      end else if (fin) begin
        state <= ST_IDLE;
      end
    end
  end

  l2s_walker #(.IDX_W(IDX_W)) u_walker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .first_addr_i (first_addr),
    .single_i     (is_single(method_i)),
    .halt_i       (fin),
    .rd_en_o      (rd_en_o),
    .rd_addr_o    (rd_addr_o),
    .chk_vld_o    (chk_vld),
    .chk_addr_o   (chk_addr),
    .chk_last_o   (chk_last)
  );

  l2s_match u_match (
    .method_i  (method_q),
    .ent_i     (rd_ent),
    .key_mac_i (key_mac_q),
    .key_fid_i (key_fid_q),
    .port_i    (port_q),
    .qual_o    (qual)
  );

  l2s_result u_result (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fin_i     (fin),
    .fin_hit_i (fin_hit),
    .fin_idx_i (chk_addr),
    .fin_ent_i (rd_ent),
    .done_o    (done_o),
    .hit_o     (hit_o),
    .index_o   (index_o),
    .entry_o   (res_ent)
  );

  assign entry_o = res_ent;

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable({hit_o, index_o, entry_o}));

  p_read_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> busy_o);

  p_rsv_noread_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RSV) |-> !rd_en_o);

  p_rsv_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_reserved(method_q)) |-> !hit_o);

  p_key_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o && method_q == M_KEY) |-> (index_o == key_slot(key_mac_q, key_fid_q)));

  p_port_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o && method_q == M_NEXT_PORT) |-> (res_ent.port == port_q && !res_ent.mac[MC_BIT]));

  p_mc_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o && method_q == M_NEXT_MC) |-> res_ent.mac[MC_BIT]);
endmodule

// File: tb/l2s_search_unit_bench.sv
module l2s_search_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  method_i = '0;
  logic [10:0] start_addr_i = '0;
  logic [3:0]  port_i = '0;
  logic [47:0] key_mac_i = '0;
  logic [11:0] key_fid_i = '0;
  logic        busy_o, rd_en_o, done_o, hit_o;
  logic [10:0] rd_addr_o, index_o;
  logic [65:0] rd_data_i = '0;
  logic [65:0] entry_o;

  logic [65:0] tbl [2048];
  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int cyc_cnt = 0;

  always #10 clk_i = ~clk_i;

  l2s_search_unit u_l2s_search_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .method_i(method_i),
    .start_addr_i(start_addr_i), .port_i(port_i), .key_mac_i(key_mac_i),
    .key_fid_i(key_fid_i), .busy_o(busy_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .done_o(done_o), .hit_o(hit_o), .index_o(index_o),
    .entry_o(entry_o)
  );

  always @(posedge clk_i) begin
    cyc_cnt <= cyc_cnt + 1;
    if (rd_en_o) begin
      rd_data_i <= tbl[rd_addr_o];
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [65:0] mk(input bit v, input logic [47:0] mac, input logic [11:0] fid,
                                     input logic [3:0] pt, input bit st);
    return {v, mac, fid, pt, st};
  endfunction

  function automatic bit qualifies(input int m, input logic [65:0] e, input logic [3:0] pt,
                                   input logic [47:0] mac, input logic [11:0] fid);
    bit v  = e[65];
    bit mc = e[57];
    case (m)
      0: return v && e[64:17] == mac && e[16:5] == fid;
      1, 2: return v;
      3: return v && !mc;
      4: return v && mc;
      7: return v && !mc && e[4:1] == pt;
      default: return 0;
    endcase
  endfunction

  task automatic model(input int m, input int sa, input logic [3:0] pt, input logic [47:0] mac,
                       input logic [11:0] fid, output bit h, output int idx, output int lat);
    h = 0; idx = 0;
    if (m == 5 || m == 6) begin lat = 1; return; end
    if (m == 0 || m == 1) begin
      idx = (m == 0) ? int'((mac ^ {36'd0, fid}) & 48'h7FF) : sa;
      h   = qualifies(m, tbl[idx], pt, mac, fid);
      lat = 2;
      return;
    end
    for (int a = sa; a < 2048; a++) begin
      if (qualifies(m, tbl[a], pt, mac, fid)) begin h = 1; idx = a; lat = 2 + (a - sa); return; end
    end
    lat = 1 + (2048 - sa);
  endtask

  task automatic run(input int m, input int sa, input logic [3:0] pt, input logic [47:0] mac,
                     input logic [11:0] fid, input bit inj, input string req);
    bit eh; int ei, el; int seen; int rd0;
    bit h_at; logic [10:0] i_at; logic [65:0] e_at;
    model(m, sa, pt, mac, fid, eh, ei, el);
    @(negedge clk_i);
    rd0 = rd_cnt;
    start_i = 1; method_i = 3'(m); start_addr_i = 11'(sa); port_i = pt;
    key_mac_i = mac; key_fid_i = fid;
    @(negedge clk_i);
    start_i = 0;
    seen = -1; h_at = 0; i_at = '0; e_at = '0;
    for (int c = 1; c <= el + 2; c++) begin
      @(negedge clk_i);
      if (inj && c == 5) begin start_i = 1; method_i = 3'd1; start_addr_i = 11'd120; end
      if (inj && c == 6) start_i = 0;
      if (done_o) begin
        if (seen < 0) seen = c;
        else seen = -2;
      end
      if (c == el) begin h_at = hit_o; i_at = index_o; e_at = entry_o; end
    end
    check(seen == el, {req, " done cycle"}, 66'(seen), 66'(el));
    check(h_at == eh, {req, " hit"}, 66'(h_at), 66'(eh));
    if (eh) begin
      check(i_at == 11'(ei), {req, " index"}, 66'(i_at), 66'(ei));
      check(e_at == tbl[ei], {req, " entry"}, e_at, tbl[ei]);
      check(hit_o == eh && index_o == i_at && entry_o == e_at, {req, " R9 hold"},
            {hit_o, index_o}, {eh, i_at});
    end
    check(!busy_o, {req, " idle after"}, 66'(busy_o), 66'(0));
    if (m == 5 || m == 6)
      check(rd_cnt == rd0, "R8 no reads", 66'(rd_cnt - rd0), 66'(0));
    if (m == 0 || m == 1)
      check(rd_cnt == rd0 + 1, {req, " one read"}, 66'(rd_cnt - rd0), 66'(1));
  endtask

  initial begin
    int kslot;
    for (int i = 0; i < 2048; i++) tbl[i] = '0;
    tbl[0]    = mk(1, 48'h0010_2030_4050, 12'h001, 4'd0, 0);
    tbl[100]  = mk(1, 48'h0100_5E00_0001, 12'h001, 4'd1, 0);
    tbl[120]  = mk(1, 48'h0022_3344_5566, 12'h002, 4'd3, 0);
    tbl[130]  = mk(1, 48'h0022_3344_7788, 12'h002, 4'd5, 1);
    tbl[150]  = mk(0, 48'h0022_3344_9999, 12'h002, 4'd9, 0);
    tbl[2047] = mk(1, 48'h00AA_BBCC_DDEE, 12'h003, 4'd9, 0);
    kslot = int'((48'h02AB_CDEF_0123 ^ 48'h005) & 48'h7FF);
    tbl[kslot] = mk(1, 48'h02AB_CDEF_0123, 12'h005, 4'd6, 1);

    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !hit_o && !rd_en_o, "R1 reset state",
          {busy_o, done_o, hit_o, rd_en_o}, 66'(0));
    rst_ni = 1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !rd_en_o, "R1 after release", {busy_o, done_o, rd_en_o}, 66'(0));

    run(1, 120, 4'd0, '0, '0, 0, "R2 addr hit");
    run(1, 121, 4'd0, '0, '0, 0, "R2 addr miss");
    run(0, 0, 4'd0, 48'h02AB_CDEF_0123, 12'h005, 0, "R3 key hit");
    run(0, 0, 4'd0, 48'h02AB_CDEF_0123, 12'h006, 0, "R3 key empty slot");
    run(0, 0, 4'd0, 48'h02AB_CDEF_0120, 12'h006, 0, "R3 key slot collision");
    run(2, 50, 4'd0, '0, '0, 0, "R4 next valid");
    run(2, 120, 4'd0, '0, '0, 0, "R4 start on valid");
    run(3, 50, 4'd0, '0, '0, 0, "R5 next unicast");
    run(4, 0, 4'd0, '0, '0, 0, "R5 next multicast");
    run(4, 101, 4'd0, '0, '0, 0, "R7 multicast miss no wrap");
    run(7, 50, 4'd5, '0, '0, 0, "R6 port 5");
    run(7, 131, 4'd9, '0, '0, 0, "R6 port 9 skip invalid");
    run(2, 2047, 4'd0, '0, '0, 0, "R7 last index");
    run(5, 10, 4'd0, '0, '0, 0, "R8 code 5");
    run(6, 10, 4'd0, '0, '0, 0, "R8 code 6");
    run(3, 300, 4'd0, '0, '0, 1, "R10 start ignored while busy");
    run(2, 1, 4'd0, '0, '0, 0, "R11 long walk");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc_cnt >= 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc_cnt);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule